// File: doc/BRIEF.md
# Shadowed Compare Register Update Controller

This block sits between software and the comparators of one PWM timer. It holds two compare values, channel A and channel B. Software writes each value into a shadow register. The comparator only ever sees the active register. A 4-bit update-method field on each channel decides when a pending shadow value is copied into the active register. The copy can happen at once, on the timer-equals-zero strobe, on the timer-equals-period strobe, on a sync strobe, or never.

Each channel has a pending flag that the hardware drives. The flag is set while the shadow register holds a value that has not yet reached the active register. It clears on the cycle the transfer happens. Software reaches the shadow values and the method fields through a small write port with a 2-bit address. The timer counter, the comparators and the waveform logic are outside this block.

Top module: `cmp_shadow_ctrl`

## Requirements
- R1: Reset clears both shadow registers, both active registers, both method fields and both pending flags. With the method at zero, the first shadow write after reset reaches the active output one edge later.
- R2: With a method of 4'b0000, a shadow write appears on the active output after the clock edge that takes the write, and the pending flag stays 0. Strobes have no effect in this mode.
- R3: With method bit 0 set (and bit 3 clear), a pending value moves to the active output on the edge that samples `tmr_zero_i`. The other strobes alone do not move it.
- R4: With method bit 1 set (and bit 3 clear), a pending value moves on the edge that samples `tmr_period_i`.
- R5: With method bit 2 set (and bit 3 clear), a pending value moves on the edge that samples `sync_i`.
- R6: Method bit 3 overrides bits 0 to 2. The active output never changes, and a written value leaves the pending flag at 1.
- R7: When several of bits 0 to 2 are set, any one of the selected strobes causes the transfer.
- R8: In an event method, a shadow write sets the pending flag on the next edge. A later write before the transfer replaces the pending value, and only the latest value reaches the active output.
- R9: When a shadow write and a selected strobe fall in the same cycle, the newly written value is transferred and the pending flag ends that cycle at 0.
- R10: The two channels are independent. A write or method change on one channel never alters the other channel's active value or pending flag.
- R11: The write address is decoded as follows: 0 is the A shadow value, 1 is the A method (taken from `wr_data_i[3:0]`), 2 is the B shadow value and 3 is the B method. A method write takes effect from the following cycle. The transfer in the cycle of the method write uses the old method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (see R11) |
| wr_data_i | input | VAL_W | Write data |
| tmr_zero_i | input | 1 | Timer-equals-zero strobe |
| tmr_period_i | input | 1 | Timer-equals-period strobe |
| sync_i | input | 1 | Sync strobe |
| act_a_o | output | VAL_W | Active compare value, channel A |
| act_b_o | output | VAL_W | Active compare value, channel B |
| pend_a_o | output | 1 | Transfer pending, channel A |
| pend_b_o | output | 1 | Transfer pending, channel B |

## Verification
The bench builds the block with VAL_W set to 8. This keeps every written value distinct and easy to read, while the method field keeps its full 4 bits. For both channels, the bench sweeps all 16 method codes against each strobe on its own, against all strobes together, against repeated writes and against a write that coincides with a strobe. This covers every combination of the override bit and the event bits. Each step also compares the channel that was not addressed, and a reset is applied mid-run to confirm that a pending state is cleared.

// File: rtl/cmp_shadow_pkg.sv
package cmp_shadow_pkg;

   localparam int METH_W    = 4;
   localparam int CH_NUM    = 2;
   localparam int ADDR_W    = $clog2(2 * CH_NUM);

   // method bit positions (decoded by the event selector)
   localparam int MB_ZERO   = 0;
   localparam int MB_PERIOD = 1;
   localparam int MB_SYNC   = 2;
   localparam int MB_HOLD   = 3;

   typedef logic [METH_W-1:0] meth_t;

   typedef struct packed {
      logic sync;
      logic period;
      logic zero;
   } evt_t;

endpackage

// File: rtl/cmp_wr_decode.sv
module cmp_wr_decode
   import cmp_shadow_pkg::*;
#(
   parameter int NCH = CH_NUM
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic [NCH-1:0]    val_we_o,
   output logic [NCH-1:0]    meth_we_o
);

   localparam int SLOTS = 2 * NCH;

   if (SLOTS > (1 << ADDR_W)) begin : g_bad_map
      $error("cmp_wr_decode: address width too small for channel count");
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
      localparam logic [ADDR_W-1:0] VAL_ADDR  = ADDR_W'(2 * ch);
      localparam logic [ADDR_W-1:0] METH_ADDR = ADDR_W'(2 * ch + 1);
      assign val_we_o[ch]  = wr_en_i && (wr_addr_i == VAL_ADDR);
      assign meth_we_o[ch] = wr_en_i && (wr_addr_i == METH_ADDR);
   end

endmodule

// File: rtl/cmp_event_sel.sv
module cmp_event_sel
   import cmp_shadow_pkg::*;
(
   input  meth_t meth_i,
   input  evt_t  evt_i,
   output logic  fire_o
);

   logic [2:0] evt_vec;
   logic       immediate;
   logic       hold;
   logic       any_sel;

   assign evt_vec[MB_ZERO]   = evt_i.zero;
   assign evt_vec[MB_PERIOD] = evt_i.period;
   assign evt_vec[MB_SYNC]   = evt_i.sync;

   assign immediate = (meth_i == '0);
   assign hold      = meth_i[MB_HOLD];
   assign any_sel   = |(meth_i[2:0] & evt_vec);

   // the hold bit beats every event bit
   assign fire_o = immediate || (!hold && any_sel);

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
   import cmp_shadow_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             val_we_i,
   input  logic             meth_we_i,
   input  logic [VAL_W-1:0] wdata_i,
   input  evt_t             evt_i,
   output logic [VAL_W-1:0] act_o,
   output logic             pend_o
);

   if (VAL_W < METH_W) begin : g_bad_width
      $error("cmp_channel: VAL_W must hold the method field");
   end

   logic [VAL_W-1:0] shadow_q, shadow_d;
   logic [VAL_W-1:0] act_q;
   logic             pend_q, pend_d;
   meth_t            meth_q;
   logic             fire;
   logic             xfer;

   cmp_event_sel u_sel (
      .meth_i (meth_q),
      .evt_i  (evt_i),
      .fire_o (fire)
   );

   always_comb begin
      shadow_d = val_we_i ? wdata_i : shadow_q;
      pend_d   = val_we_i | pend_q;
   end

   assign xfer = fire && pend_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shadow_q <= '0;
         act_q    <= '0;
         pend_q   <= 1'b0;
         meth_q   <= '0;
      end else begin
         shadow_q <= shadow_d;
         if (xfer) begin
            act_q  <= shadow_d;
            pend_q <= 1'b0;
         end else begin
            pend_q <= pend_d;
         end
         if (meth_we_i) meth_q <= wdata_i[METH_W-1:0];
      end
   end

   assign act_o  = act_q;
   assign pend_o = pend_q;

   p_imm_no_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meth_q == '0) |=> !pend_q);

   p_hold_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      meth_q[MB_HOLD] |=> $stable(act_q));

   p_write_pends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (val_we_i && !fire) |=> pend_q);

   p_fire_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire |=> !pend_q);

   p_fell_matches_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q) |-> (act_q == shadow_q));

   p_quiet_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire |=> $stable(act_q));

endmodule

// File: rtl/cmp_shadow_ctrl.sv
module cmp_shadow_ctrl
   import cmp_shadow_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [VAL_W-1:0] wr_data_i,
   input  logic             tmr_zero_i,
   input  logic             tmr_period_i,
   input  logic             sync_i,
   output logic [VAL_W-1:0] act_a_o,
   output logic [VAL_W-1:0] act_b_o,
   output logic             pend_a_o,
   output logic             pend_b_o
);

   if (ADDR_W != 2) begin : g_bad_addr
      $error("cmp_shadow_ctrl: address port width mismatch");
   end

   logic [CH_NUM-1:0] val_we, meth_we;
   logic [VAL_W-1:0]  act   [CH_NUM];
   logic [CH_NUM-1:0] pend;
   evt_t              evt;

   assign evt.zero   = tmr_zero_i;
   assign evt.period = tmr_period_i;
   assign evt.sync   = sync_i;

   cmp_wr_decode #(.NCH(CH_NUM)) u_dec (
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .val_we_o  (val_we),
      .meth_we_o (meth_we)
   );

   for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
      cmp_channel #(.VAL_W(VAL_W)) u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .val_we_i  (val_we[ch]),
         .meth_we_i (meth_we[ch]),
         .wdata_i   (wr_data_i),
         .evt_i     (evt),
         .act_o     (act[ch]),
         .pend_o    (pend[ch])
      );
   end

   assign act_a_o  = act[0];
   assign act_b_o  = act[1];
   assign pend_a_o = pend[0];
   assign pend_b_o = pend[1];

   p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({val_we, meth_we}) <= 1);

   p_b_untouched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i[1] == 1'b0 && !tmr_zero_i && !tmr_period_i && !sync_i
       && !pend_b_o) |=> $stable(act_b_o));

endmodule

// File: tb/cmp_shadow_ctrl_test.sv
`timescale 1ns/1ps
module cmp_shadow_ctrl_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         ev_z = 1'b0, ev_p = 1'b0, ev_s = 1'b0;
   logic [W-1:0] act_a, act_b;
   logic         pend_a, pend_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_act [2];
   logic [W-1:0] m_sh  [2];
   logic         m_pend[2];
   logic [3:0]   m_meth[2];

   always #2 clk = ~clk;

   cmp_shadow_ctrl #(.VAL_W(W)) uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .tmr_zero_i(ev_z), .tmr_period_i(ev_p), .sync_i(ev_s),
      .act_a_o(act_a), .act_b_o(act_b), .pend_a_o(pend_a), .pend_b_o(pend_b)
   );

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_act[c] = '0; m_sh[c] = '0; m_pend[c] = 1'b0; m_meth[c] = '0;
      end
   endtask

   task automatic chk(input int c, input string tag);
      logic [W-1:0] a;
      logic         p;
      a = (c == 0) ? act_a : act_b;
      p = (c == 0) ? pend_a : pend_b;
      checks++;
      if (a !== m_act[c] || p !== m_pend[c]) begin
         fails++;
         $display("FAIL %s ch%0d: act=%0h exp=%0h pend=%0b exp=%0b",
                  tag, c, a, m_act[c], p, m_pend[c]);
      end
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   task automatic step(input logic we, input logic [1:0] ad, input logic [W-1:0] d,
                       input logic z, input logic p, input logic s,
                       input string tag, input int focus);
      logic fire;
      wr_en = we; wr_addr = ad; wr_data = d; ev_z = z; ev_p = p; ev_s = s;
      @(posedge clk);
      for (int c = 0; c < 2; c++) begin
         logic pn;
         logic [W-1:0] sh;
         sh = m_sh[c]; pn = m_pend[c];
         if (we && ad == 2'(2 * c)) begin sh = d; pn = 1'b1; end
         fire = (m_meth[c] == 4'd0) ||
                (!m_meth[c][3] && ((m_meth[c][0] && z) || (m_meth[c][1] && p) ||
                                   (m_meth[c][2] && s)));
         m_sh[c] = sh;
         if (fire && pn) begin m_act[c] = sh; pn = 1'b0; end
         m_pend[c] = pn;
         if (we && ad == 2'(2 * c + 1)) m_meth[c] = d[3:0];
      end
      @(negedge clk);
      wr_en = 1'b0; ev_z = 1'b0; ev_p = 1'b0; ev_s = 1'b0;
      chk(focus, tag);
      chk(1 - focus, "R10");
   endtask

   function automatic string tag_for(input logic [3:0] m, input int e);
      if (m == 4'd0) return "R2";
      if (m[3]) return "R6";
      if ($countones(m[2:0]) > 1) return "R7";
      if (e == 0) return "R3";
      if (e == 1) return "R4";
      return "R5";
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: act=timeout exp=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      model_reset();
      repeat (3) @(negedge clk);
      chk(0, "R1"); chk(1, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      // R1: method resets to immediate
      step(1'b1, 2'd0, 8'h5A, 1'b0, 1'b0, 1'b0, "R1", 0);
      step(1'b1, 2'd2, 8'hA5, 1'b0, 1'b0, 1'b0, "R1", 1);

      for (int c = 0; c < 2; c++) begin
         for (int m = 0; m < 16; m++) begin
            logic [W-1:0] v;
            v = W'(c * 100 + m * 5 + 1);
            step(1'b1, 2'(2 * c + 1), W'(m), 1'b0, 1'b0, 1'b0, "R11", c);
            step(1'b1, 2'(2 * c), v, 1'b0, 1'b0, 1'b0, tag_for(4'(m), 0), c);
            for (int e = 0; e < 3; e++) begin
               step(1'b0, 2'd0, '0, e == 0, e == 1, e == 2, tag_for(4'(m), e), c);
               // re-arm the pending value between strobes
               step(1'b1, 2'(2 * c), W'(v + W'(e) + 8'd7), 1'b0, 1'b0, 1'b0, "R8", c);
            end
            step(1'b1, 2'(2 * c), W'(v ^ 8'h33), 1'b0, 1'b0, 1'b0, "R8", c);
            step(1'b1, 2'(2 * c), W'(v ^ 8'h5C), 1'b0, 1'b0, 1'b0, "R8", c);
            step(1'b0, 2'd0, '0, 1'b1, 1'b1, 1'b1, tag_for(4'(m), 0), c);
            step(1'b1, 2'(2 * c), W'(v ^ 8'hC3), 1'b1, 1'b0, 1'b0, "R9", c);
            step(1'b1, 2'(2 * c), W'(v ^ 8'h96), 1'b0, 1'b1, 1'b1, "R9", c);
         end
      end

      // leave A pending under hold, then reset mid-run
      step(1'b1, 2'd1, 8'h08, 1'b0, 1'b0, 1'b0, "R11", 0);
      step(1'b1, 2'd0, 8'hEE, 1'b1, 1'b1, 1'b1, "R6", 0);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      chk(0, "R1"); chk(1, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b1, 2'd0, 8'h11, 1'b0, 1'b0, 1'b0, "R1", 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule